// File: doc/BRIEF.md
# Receive Byte Buffer with Idle Timeout

This block sits between a serial receive deserializer and a host bus. Each completed byte comes in on a one-cycle valid strobe. The block stores the byte and hands it to the host on a one-cycle read strobe. A static mode input selects one of two storage modes:

- A single holding register.
- A first-in first-out queue with a programmable fill threshold.

A ten-bit status word reports:

- full and empty;
- a combined "holding register occupied / threshold reached" flag;
- an idle-timeout flag;
- the timeout interrupt enable bit.

Two interrupt request outputs are driven from this status. The receive request follows the combined flag, gated by an enable input. The timeout request follows the timeout flag, gated by the stored enable bit.

The idle timer counts clock cycles while data is stored and the queue is not full. It flags bytes that have sat below the threshold for too long, so the host collects them without waiting for the threshold interrupt. A byte that arrives while the storage is full is discarded.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, status is 0x100: only bit 8 (empty) is set, and both enable bits read 0. Both interrupt outputs are 0, and rd_data is 0.
- R2: With fifo_en=1, up to DEPTH (16) bytes are stored. They are returned in arrival order. rd_data shows the byte on the cycle after the clock edge that sampled rd_stb.
- R3: Status bit 9 (full) is 1 when the stored count equals the capacity (DEPTH when fifo_en=1, 1 when fifo_en=0). A byte strobed while full is discarded, and the stored bytes and their order are unchanged.
- R4: Status bit 8 (empty) is 1 when nothing is stored. A read strobe while empty leaves rd_data at the last byte read and moves no pointer.
- R5: With fifo_en=0, the block holds one byte. Status bit 3 is 1 exactly while that byte is unread, and a second byte arriving before the read is discarded.
- R6: With fifo_en=1, status bit 3 is 1 when the stored count is at least fifo_thresh. A threshold value of 0 counts as 1.
- R7: rx_irq equals status bit 3 ANDed with rx_irq_en.
- R8: Status bit 7 (timeout) becomes 1 after TMO_CYCLES consecutive clock edges with data stored, storage not full, and neither byte_vld nor rd_stb. It returns to 0 on the edge that samples either strobe.
- R9: The idle timer is held at zero while storage is empty or full. No timeout is flagged in either state, however long it lasts.
- R10: Status bit 6 holds the timeout enable, written from tmo_en_wdata when tmo_en_we is high and reset to 0. tmo_irq equals bit 7 ANDed with bit 6.
- R11: Status bits 5, 4, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register; change only while empty |
| fifo_thresh | input | THW (4) | Queue fill threshold |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tmo_en_we | input | 1 | Write strobe for the timeout enable bit |
| tmo_en_wdata | input | 1 | Value written to the timeout enable bit |
| byte_vld | input | 1 | One-cycle strobe: byte_in holds a received byte |
| byte_in | input | DW (8) | Received byte |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_data | output | DW (8) | Last byte read |
| status | output | 10 | Status word (bits 9 full, 8 empty, 7 timeout, 6 timeout enable, 3 occupied/threshold) |
| rx_irq | output | 1 | Receive interrupt request |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
The hardest situation to reach is the exact timeout boundary combined with the hold conditions. The flag must rise on exactly the TMO_CYCLES-th idle edge, must not rise while the queue is full, and must not rise while it is empty. The bench lowers the timeout limit and counts negative edges after the last strobe, checking the flag one edge before and on the boundary edge. It then refills the queue to capacity and idles well past the limit to show that the held timer never trips. The full-drop case is reached by pushing one byte past capacity and then draining the whole queue, so a lost or overwritten entry shows up in the read order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned ST_W     = 10;
  localparam int unsigned ST_FULL  = 9;
  localparam int unsigned ST_EMPTY = 8;
  localparam int unsigned ST_TMO   = 7;
  localparam int unsigned ST_TMOEN = 6;
  localparam int unsigned ST_LVL   = 3;

  // Capacity of the storage in the selected mode.
  function automatic int unsigned room_of(input logic fifo_on, input int unsigned depth);
    return fifo_on ? depth : 1;
  endfunction

  // Effective trip level: a zero threshold behaves as one.
  function automatic int unsigned trip_of(input int unsigned thr);
    return (thr == 0) ? 1 : thr;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level
);
  import rxq_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      pop_data <= '0;
    end else begin
      if (push) wptr <= AW'(wrap_inc(int'(wptr), DEPTH));
      if (pop) begin
        rptr     <= AW'(wrap_inc(int'(rptr), DEPTH));
        pop_data <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH)) |-> (!push || pop));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !pop);
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || hold)   cnt <= '0;
    else if (cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(LIMIT));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !expired);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned THW        = 4,
  parameter int unsigned TMO_CYCLES = 1000,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_en,
  input  logic [THW-1:0] fifo_thresh,
  input  logic           rx_irq_en,
  input  logic           tmo_en_we,
  input  logic           tmo_en_wdata,
  input  logic           byte_vld,
  input  logic [DW-1:0]  byte_in,
  input  logic           rd_stb,
  output logic [DW-1:0]  rd_data,
  output logic [9:0]     status,
  output logic           rx_irq,
  output logic           tmo_irq
);
  import rxq_pkg::*;

  logic [CW-1:0] level, room, trip;
  logic is_full, is_empty, push_ok, pop_ok, lvl_flag, tmo_hit, tmo_en_q;

  assign room     = CW'(room_of(fifo_en, DEPTH));
  assign trip     = CW'(trip_of(int'(fifo_thresh)));
  assign is_full  = (level >= room);
  assign is_empty = (level == '0);
  assign push_ok  = byte_vld && !is_full;
  assign pop_ok   = rd_stb && !is_empty;
  assign lvl_flag = fifo_en ? (level >= trip) : !is_empty;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push_ok), .push_data(byte_in),
    .pop(pop_ok), .pop_data(rd_data),
    .level(level)
  );

  rxq_idle #(.LIMIT(TMO_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .restart(byte_vld || rd_stb),
    .hold(is_empty || is_full),
    .expired(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmo_en_q <= 1'b0;
    else if (tmo_en_we) tmo_en_q <= tmo_en_wdata;
  end

  always_comb begin
    status           = '0;
    status[ST_FULL]  = is_full;
    status[ST_EMPTY] = is_empty;
    status[ST_TMO]   = tmo_hit;
    status[ST_TMOEN] = tmo_en_q;
    status[ST_LVL]   = lvl_flag;
  end

  assign rx_irq  = lvl_flag && rx_irq_en;
  assign tmo_irq = tmo_hit && tmo_en_q;

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && byte_vld && !rd_stb) |=> $stable(level));
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_stb && !byte_vld) |=> $stable(rd_data));
  // R8
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_hit) |-> $past(!byte_vld && !rd_stb && !is_empty && !is_full));
endmodule

// File: tb/tb_rxq_buffer.sv
module tb_rxq_buffer;
  localparam int TMO = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b1, rx_irq_en = 1'b0, tmo_en_we = 1'b0, tmo_en_wdata = 1'b0;
  logic [3:0] fifo_thresh = 4'd3;
  logic byte_vld = 1'b0, rd_stb = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] rd_data;
  logic [9:0] status;
  logic rx_irq, tmo_irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxq_buffer #(.TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_thresh(fifo_thresh),
    .rx_irq_en(rx_irq_en), .tmo_en_we(tmo_en_we), .tmo_en_wdata(tmo_en_wdata),
    .byte_vld(byte_vld), .byte_in(byte_in), .rd_stb(rd_stb),
    .rd_data(rd_data), .status(status), .rx_irq(rx_irq), .tmo_irq(tmo_irq)
  );

  // {op, data, expect}: op 0 push, 1 pop and compare rd_data, 2 compare status[3]
  localparam logic [17:0] VEC [12] = '{
    {2'd0, 8'h11, 8'h00}, {2'd0, 8'h22, 8'h00}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'h33, 8'h00}, {2'd2, 8'h00, 8'h01}, {2'd1, 8'h00, 8'h11},
    {2'd2, 8'h00, 8'h00}, {2'd0, 8'h44, 8'h00}, {2'd0, 8'h55, 8'h00},
    {2'd1, 8'h00, 8'h22}, {2'd1, 8'h00, 8'h33}, {2'd1, 8'h00, 8'h44}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk(status == 10'h100, "R1 status", status, 10'h100);
    chk(!rx_irq && !tmo_irq, "R1 irqs", {rx_irq, tmo_irq}, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    rx_irq_en = 1'b1;
    idle(1);

    // R2 R6 table walk, threshold 3
    for (int i = 0; i < 12; i++) begin
      case (VEC[i][17:16])
        2'd0: push(VEC[i][15:8]);
        2'd1: begin pop(); chk(rd_data == VEC[i][7:0], "R2 order", rd_data, VEC[i][7:0]); end
        default: chk(status[3] == VEC[i][0], "R6 threshold", status[3], VEC[i][0]);
      endcase
    end
    pop();
    chk(rd_data == 8'h55, "R2 last", rd_data, 8'h55);

    // R4 empty and read while empty
    chk(status[8] == 1'b1, "R4 empty", status[8], 1);
    pop();
    chk(rd_data == 8'h55, "R4 empty read keeps data", rd_data, 8'h55);
    push(8'hAA); pop();
    chk(rd_data == 8'hAA, "R4 pointers unchanged", rd_data, 8'hAA);

    // R3 fill, drop, drain
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    chk(status[9] == 1'b1, "R3 full", status[9], 1);
    chk(status[3] && rx_irq, "R7 irq with enable", {status[3], rx_irq}, 3);
    chk((status & 10'h037) == 0, "R11 spare bits", status & 10'h037, 0);
    rx_irq_en = 1'b0;
    idle(1);
    chk(!rx_irq, "R7 irq masked", rx_irq, 0);
    // R9 timer held while full
    idle(TMO + 5);
    chk(status[7] == 1'b0, "R9 no timeout when full", status[7], 0);
    push(8'hFF);
    for (int i = 0; i < 16; i++) begin
      pop();
      chk(rd_data == 8'h40 + 8'(i), "R3 drop keeps contents", rd_data, 8'h40 + i);
    end
    chk(status[8] == 1'b1, "R3 drained to empty", status[8], 1);
    // R9 timer held while empty
    idle(TMO + 5);
    chk(status[7] == 1'b0, "R9 no timeout when empty", status[7], 0);

    // R6 zero threshold
    fifo_thresh = 4'd0;
    idle(1);
    chk(status[3] == 1'b0, "R6 zero thr empty", status[3], 0);
    push(8'h01);
    chk(status[3] == 1'b1, "R6 zero thr as one", status[3], 1);
    pop();

    // R5 single holding register
    fifo_en = 1'b0;
    idle(1);
    chk(status[3] == 1'b0, "R5 holding empty", status[3], 0);
    push(8'h5A);
    chk(status[3] && status[9], "R5 holding full", status[9:8], 2);
    push(8'hA5);
    pop();
    chk(rd_data == 8'h5A, "R5 second byte dropped", rd_data, 8'h5A);
    chk(status[3] == 1'b0, "R5 holding read", status[3], 0);
    pop();
    chk(rd_data == 8'h5A, "R5 empty read", rd_data, 8'h5A);

    // R8 R10 timeout
    fifo_en = 1'b1; fifo_thresh = 4'd8;
    push(8'h77);
    idle(TMO - 1);
    chk(status[7] == 1'b0, "R8 before limit", status[7], 0);
    idle(1);
    chk(status[7] == 1'b1, "R8 at limit", status[7], 1);
    chk(!tmo_irq, "R10 irq disabled", tmo_irq, 0);
    @(negedge clk); tmo_en_we = 1'b1; tmo_en_wdata = 1'b1;
    @(negedge clk); tmo_en_we = 1'b0;
    chk(status[6] && tmo_irq, "R10 enable and irq", {status[6], tmo_irq}, 3);
    push(8'h78);
    chk(status[7] == 1'b0, "R8 cleared by byte", status[7], 0);
    idle(TMO);
    chk(status[7] == 1'b1, "R8 second expiry", status[7], 1);
    pop();
    chk(status[7] == 1'b0 && !tmo_irq, "R8 cleared by read", status[7], 0);
    chk(rd_data == 8'h77, "R2 timeout data", rd_data, 8'h77);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule